// File: doc/BRIEF.md
# Iterative Decimal Multiplier with Carry-Save Accumulation

This block multiplies two unsigned N-digit decimal integers, each given as packed 4-bit BCD digits, and returns the 2N-digit BCD product. It works one multiplier digit per clock. The multiplier is scanned from its least significant digit upward.

When a job starts, the block prepares a small set of multiplicand multiples: zero, one, two, four and five times X. Each of these is formed digit by digit without any carry ripple. Every multiplier digit in 0..9 names two of these multiples, and their sum is that digit times X. Each iteration adds both selected multiples into a running sum. This running sum is kept in decimal carry-save form: one BCD digit per position plus one pending carry bit per position. It is updated by two rows of per-digit BCD adders that do not propagate carries across positions.

After each addition the accumulator shifts one decimal place toward the least significant end. The digit that leaves at the bottom is a finished low product digit. After N iterations, one BCD carry-propagate addition merges the saved digits and carries into the upper N product digits. A host pulses `start` with the operands valid, waits for the one-cycle `done` pulse, and reads `product`. The product then holds until the next job completes.

Control is a five-state machine:
- IDLE goes to PREP when `start` is high.
- PREP goes to RUN unconditionally.
- RUN stays in RUN for N cycles, then goes to FINAL after the last multiplier digit.
- FINAL goes to DONE.
- DONE goes back to IDLE.

Top module: `bcd_seq_mult`

## Requirements
- R1: While reset is held and right after it, `busy` and `done` are 0 and `product` is all zeros.
- R2: For operands made only of valid BCD digits (each nibble 0..9, digit i at bits [4i+3:4i]), `product` equals X times Y as 2N packed BCD digits, least significant digit in bits [3:0].
- R3: `done` is high for exactly one cycle, namely the cycle after the (N+2)th rising edge following the edge that samples `start` in IDLE.
- R4: `busy` is high from the cycle after the accepted `start` through the `done` cycle inclusive, and is low in the cycle after `done`.
- R5: `start` and operand changes while `busy` is high are ignored: the result and the `done` timing are those of the accepted job, and no second job follows.
- R6: Outside a job, `product` keeps its last value whatever `x_in`, `y_in` do, as long as `start` stays low.
- R7: Every multiplier digit value 0..9 gives the correct partial product, including the case where every digit of both operands is 9 (the largest product, with carries reaching the top digit).
- R8: A zero multiplicand or a zero multiplier gives an all-zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a job when the block is idle |
| x_in | input | 4*N | Multiplicand, packed BCD |
| y_in | input | 4*N | Multiplier, packed BCD |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 8*N | Product, packed BCD, held until the next job finishes |

## Verification
The multiplier operands are chosen so that every digit value 0..9 selects its pair of multiples at least once, in both rising and falling digit orders. A mismatch then points to a specific pair choice or to a specific doubling or halving rule. The all-nines case fills every carry-save carry bit and exercises the final merge's longest ripple. Zero operands and a multiply by one separate the accumulation path from the shift path. A mid-job restart attempt with new operands shows whether the operand registers or the state machine leak input changes.

// File: rtl/bcd_seq_mult_pkg.sv
package bcd_seq_mult_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_RUN,
        ST_FINAL,
        ST_DONE
    } state_e;

    typedef enum logic [2:0] {
        SEL_ZERO,
        SEL_ONE,
        SEL_TWO,
        SEL_FOUR,
        SEL_FIVE
    } mult_sel_e;

    typedef struct packed {
        mult_sel_e first;
        mult_sel_e second;
    } sel_pair_t;

    // Two easy multiples whose sum is digit times X
    function automatic sel_pair_t pick_pair(input logic [3:0] d);
        sel_pair_t p;
        case (d)
            4'd1:    p = '{SEL_ONE,  SEL_ZERO};
            4'd2:    p = '{SEL_TWO,  SEL_ZERO};
            4'd3:    p = '{SEL_TWO,  SEL_ONE};
            4'd4:    p = '{SEL_FOUR, SEL_ZERO};
            4'd5:    p = '{SEL_FIVE, SEL_ZERO};
            4'd6:    p = '{SEL_FIVE, SEL_ONE};
            4'd7:    p = '{SEL_FIVE, SEL_TWO};
            4'd8:    p = '{SEL_FOUR, SEL_FOUR};
            4'd9:    p = '{SEL_FIVE, SEL_FOUR};
            default: p = '{SEL_ZERO, SEL_ZERO};
        endcase
        return p;
    endfunction

    // One decimal digit add: {carry, digit}
    function automatic logic [4:0] digit_add(input logic [3:0] a, input logic [3:0] b,
                                             input logic c);
        logic [4:0] s;
        logic [4:0] t;
        s = 5'(a) + 5'(b) + 5'(c);
        t = s - 5'd10;
        if (s > 5'd9) return {1'b1, t[3:0]};
        return {1'b0, s[3:0]};
    endfunction

    // Digit add where the outgoing carry is known to be zero
    function automatic logic [3:0] digit_add_top(input logic [3:0] a, input logic [3:0] b,
                                                 input logic c);
        logic [4:0] s;
        logic [4:0] t;
        s = 5'(a) + 5'(b) + 5'(c);
        t = s - 5'd10;
        return (s > 5'd9) ? t[3:0] : s[3:0];
    endfunction

    // Digit of 2X from the current digit and the digit below it
    function automatic logic [3:0] dbl_digit(input logic [3:0] cur, input logic [3:0] low);
        logic [4:0] t;
        t = {cur, 1'b0};
        if (t >= 5'd10) t = t - 5'd10;
        return t[3:0] + {3'b000, (low >= 4'd5)};
    endfunction

    // Digit of 5X from the current digit and the digit below it
    function automatic logic [3:0] quint_digit(input logic [3:0] cur, input logic [3:0] low);
        return (cur[0] ? 4'd5 : 4'd0) + {1'b0, low[3:1]};
    endfunction

endpackage

// File: rtl/bcd_multiples.sv
module bcd_multiples
    import bcd_seq_mult_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic [4*DIGITS-1:0]     x,
    output logic [4*(DIGITS+1)-1:0] x2,
    output logic [4*(DIGITS+1)-1:0] x4,
    output logic [4*(DIGITS+1)-1:0] x5
);
    localparam int W = DIGITS + 1;

    logic [4*W-1:0] xe;
    assign xe = {4'b0000, x};

    for (genvar g = 0; g < W; g++) begin : g_dig
        if (g == 0) begin : g_lsd
            assign x2[3:0] = dbl_digit(xe[3:0], 4'd0);
            assign x4[3:0] = dbl_digit(x2[3:0], 4'd0);
            assign x5[3:0] = quint_digit(xe[3:0], 4'd0);
        end else begin : g_up
            assign x2[4*g+:4] = dbl_digit(xe[4*g+:4], xe[4*(g-1)+:4]);
            assign x4[4*g+:4] = dbl_digit(x2[4*g+:4], x2[4*(g-1)+:4]);
            assign x5[4*g+:4] = quint_digit(xe[4*g+:4], xe[4*(g-1)+:4]);
        end
    end
endmodule

// File: rtl/bcd_digit_row.sv
module bcd_digit_row
    import bcd_seq_mult_pkg::*;
#(
    parameter int DIGITS = 9
) (
    input  logic [4*DIGITS-1:0] a,
    input  logic [4*DIGITS-1:0] b,
    input  logic [DIGITS-1:0]   cin,
    output logic [4*DIGITS-1:0] sum,
    output logic [DIGITS-2:0]   cout
);
    for (genvar g = 0; g < DIGITS; g++) begin : g_pos
        if (g < DIGITS - 1) begin : g_lo
            logic [4:0] r;
            assign r            = digit_add(a[4*g+:4], b[4*g+:4], cin[g]);
            assign sum[4*g+:4]  = r[3:0];
            assign cout[g]      = r[4];
        end else begin : g_hi
            assign sum[4*g+:4]  = digit_add_top(a[4*g+:4], b[4*g+:4], cin[g]);
        end
    end
endmodule

// File: rtl/bcd_cpa.sv
module bcd_cpa
    import bcd_seq_mult_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic [4*DIGITS-1:0] a,
    input  logic [4*DIGITS-1:0] b,
    output logic [4*DIGITS-1:0] sum
);
    logic [DIGITS-1:0] c;
    assign c[0] = 1'b0;

    for (genvar g = 0; g < DIGITS; g++) begin : g_pos
        if (g < DIGITS - 1) begin : g_lo
            logic [4:0] r;
            assign r           = digit_add(a[4*g+:4], b[4*g+:4], c[g]);
            assign sum[4*g+:4] = r[3:0];
            assign c[g+1]      = r[4];
        end else begin : g_hi
            assign sum[4*g+:4] = digit_add_top(a[4*g+:4], b[4*g+:4], c[g]);
        end
    end
endmodule

// File: rtl/bcd_seq_mult.sv
module bcd_seq_mult
    import bcd_seq_mult_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [4*N-1:0] x_in,
    input  logic [4*N-1:0] y_in,
    output logic           busy,
    output logic           done,
    output logic [8*N-1:0] product
);
    localparam int W  = N + 1;
    localparam int XW = 4 * N;
    localparam int MW = 4 * W;
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST_IT = CW'(N - 1);

    state_e st_q, st_d;

    logic [XW-1:0]  x_q, y_q, s_q, low_q;
    logic [N-1:0]   h_q;
    logic [CW-1:0]  cnt_q;
    logic [MW-1:0]  m2_q, m4_q, m5_q;
    logic [MW-1:0]  m2_w, m4_w, m5_w;
    logic [MW-1:0]  m1_w;
    logic [8*N-1:0] prod_q;

    // Multiples of the captured multiplicand
    bcd_multiples #(.DIGITS(N)) mult_i (
        .x  (x_q),
        .x2 (m2_w),
        .x4 (m4_w),
        .x5 (m5_w)
    );

    assign m1_w = {4'b0000, x_q};

    // Select the two multiples for the current multiplier digit
    sel_pair_t      pair;
    logic [MW-1:0]  op_a, op_b;

    function automatic logic [MW-1:0] pick_mult(input mult_sel_e s,
                                                input logic [MW-1:0] v1,
                                                input logic [MW-1:0] v2,
                                                input logic [MW-1:0] v4,
                                                input logic [MW-1:0] v5);
        case (s)
            SEL_ONE:  return v1;
            SEL_TWO:  return v2;
            SEL_FOUR: return v4;
            SEL_FIVE: return v5;
            default:  return '0;
        endcase
    endfunction

    always_comb begin
        pair = pick_pair(y_q[3:0]);
        op_a = pick_mult(pair.first,  m1_w, m2_q, m4_q, m5_q);
        op_b = pick_mult(pair.second, m1_w, m2_q, m4_q, m5_q);
    end

    // Carry-save 4:2 step: two rows of digit adders, no carry ripple
    logic [MW-1:0] row1_sum, row2_sum;
    logic [N-1:0]  row1_cy, row2_cy;

    bcd_digit_row #(.DIGITS(W)) row1_i (
        .a    ({4'b0000, s_q}),
        .b    (op_a),
        .cin  ({1'b0, h_q}),
        .sum  (row1_sum),
        .cout (row1_cy)
    );

    bcd_digit_row #(.DIGITS(W)) row2_i (
        .a    (row1_sum),
        .b    (op_b),
        .cin  ({row1_cy, 1'b0}),
        .sum  (row2_sum),
        .cout (row2_cy)
    );

    // Final merge of saved digits and carries
    logic [XW-1:0] h_dig, upper_w;

    always_comb begin
        for (int i = 0; i < N; i++) h_dig[4*i+:4] = {3'b000, h_q[i]};
    end

    bcd_cpa #(.DIGITS(N)) merge_i (
        .a   (s_q),
        .b   (h_dig),
        .sum (upper_w)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_PREP;
            ST_PREP:  st_d = ST_RUN;
            ST_RUN:   if (cnt_q == LAST_IT) st_d = ST_FINAL;
            ST_FINAL: st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy    = (st_q != ST_IDLE);
        done    = (st_q == ST_DONE);
        product = prod_q;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            s_q    <= '0;
            h_q    <= '0;
            low_q  <= '0;
            cnt_q  <= '0;
            m2_q   <= '0;
            m4_q   <= '0;
            m5_q   <= '0;
            prod_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        x_q <= x_in;
                        y_q <= y_in;
                    end
                end
                ST_PREP: begin
                    m2_q  <= m2_w;
                    m4_q  <= m4_w;
                    m5_q  <= m5_w;
                    s_q   <= '0;
                    h_q   <= '0;
                    cnt_q <= '0;
                end
                ST_RUN: begin
                    s_q   <= row2_sum[MW-1:4];
                    h_q   <= row2_cy;
                    low_q <= {row2_sum[3:0], low_q[XW-1:4]};
                    y_q   <= {4'b0000, y_q[XW-1:4]};
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_FINAL: begin
                    prod_q <= {upper_w, low_q};
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bcd_seq_mult_chk.sv
module bcd_seq_mult_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic [8*N-1:0] product
);
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_inside_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_busy_until_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_busy_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_product_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(product));

    for (genvar i = 0; i < 2 * N; i++) begin : g_dig
        p_bcd_digit_r2: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (product[4*i+:4] <= 4'd9));
    end
endmodule

bind bcd_seq_mult bcd_seq_mult_chk #(.N(N)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/bcd_seq_mult_tb_top.sv
module bcd_seq_mult_tb_top;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [4*N-1:0] x_in = '0;
    logic [4*N-1:0] y_in = '0;
    logic           busy, done;
    logic [8*N-1:0] product;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    bcd_seq_mult #(.N(N)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .x_in    (x_in),
        .y_in    (y_in),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    function automatic logic [63:0] bcd_val(input logic [4*N-1:0] b);
        logic [63:0] v = 0;
        for (int i = N - 1; i >= 0; i--) v = v * 10 + 64'(b[4*i+:4]);
        return v;
    endfunction

    function automatic logic [8*N-1:0] to_bcd(input logic [63:0] v);
        logic [8*N-1:0] r = '0;
        for (int i = 0; i < 2 * N; i++) begin
            r[4*i+:4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue a job, follow it to done, verify timing, busy and result.
    // mid_edge > 0: on that edge count, new operands and start are applied.
    task automatic run_job(input logic [4*N-1:0] x, input logic [4*N-1:0] y,
                           input string req, input int mid_edge);
        logic [8*N-1:0] exp_p;
        int edges;
        bit busy_ok;
        exp_p = to_bcd(bcd_val(x) * bcd_val(y));
        @(negedge clk);
        x_in  = x;
        y_in  = y;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start   = 1'b0;
        edges   = 0;
        busy_ok = 1'b1;
        while (edges < 4 * N + 20) begin
            if (!busy) busy_ok = 1'b0;
            if (done) break;
            if (mid_edge > 0 && edges == mid_edge) begin
                x_in  = ~x;
                y_in  = {4'd9, y[4*N-5:0]};
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        start = 1'b0;
        check(edges == N + 2, {req, " R3 done latency"}, 64'(edges), 64'(N + 2));
        check(busy_ok, {req, " R4 busy through job"}, 64'(busy_ok), 64'd1);
        check(product == exp_p, {req, " R2 product"}, product, exp_p);
        @(negedge clk);
        check(!done, {req, " R3 done single cycle"}, 64'(done), 64'd0);
        check(!busy, {req, " R4 busy low after done"}, 64'(busy), 64'd0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(!busy && !done, "R1 flags in reset", {62'd0, busy, done}, 64'd0);
        check(product == '0, "R1 product in reset", product, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1 flags after reset", {62'd0, busy, done}, 64'd0);
    endtask

    task automatic test_digit_patterns();
        run_job(32'h1234_5678, 32'h9876_5432, "R7 falling digits", 0);
        run_job(32'h8765_4321, 32'h0123_4567, "R7 rising digits", 0);
        run_job(32'h5050_7319, 32'h1908_6000, "R7 mixed with zeros", 0);
        run_job(32'h0000_0001, 32'h4242_4242, "R2 times one", 0);
    endtask

    task automatic test_extremes();
        run_job(32'h9999_9999, 32'h9999_9999, "R7 all nines", 0);
        run_job(32'h0000_0000, 32'h9999_9999, "R8 zero multiplicand", 0);
        run_job(32'h9999_9999, 32'h0000_0000, "R8 zero multiplier", 0);
    endtask

    task automatic test_start_ignored();
        run_job(32'h3141_5926, 32'h2718_2818, "R5 restart mid job", 4);
        run_job(32'h0000_0007, 32'h0000_0006, "R5 restart near end", N);
    endtask

    task automatic test_hold();
        logic [8*N-1:0] held;
        held = product;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            x_in = 32'(i * 32'h1111_1111);
            y_in = ~x_in;
        end
        @(negedge clk);
        check(product == held, "R6 product held while idle", product, held);
        check(!busy && !done, "R6 no job without start", {62'd0, busy, done}, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        test_digit_patterns();
        test_extremes();
        test_start_ignored();
        test_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule